// File: doc/BRIEF.md
# Smart Card Character Engine

This block moves single characters over a half-duplex card I/O line. The receiver watches the line, samples each character at the middle of its bits, and loads the result into a receive data register. It then sets a data-full flag and raises either a data-full interrupt or, when parity failed or a character was lost, an error interrupt. The transmitter sends one character for each host write, followed by two guard bits held high, and then flags transmit end.

Only one direction is enabled at a time. The host switches direction by software. To leave receive mode it waits until the data-full, parity or overrun flag shows the character is in, then clears the receive enable and sets the transmit enable. To leave transmit mode it waits for transmit end and does the reverse. A counted DMA drain can empty the receive register without host involvement. Characters with a parity error still land in the register, but they never produce a DMA request, so the programmed count covers good bytes only.

A small register file carries the enables, the status flags, the data register, the DMA count and the bit-period divider. One bit lasts OVS*(DIV+1) clocks.

Top module: `sc_char_engine`

## Requirements
- R1: After reset all status flags, the control register and the DMA count read 0, io_out is 1, and irq_rxfull, irq_err and dma_req are 0.
- R2: A character is a low start bit, 8 data bits sent LSB first, an even-parity bit, and at least 2 high guard bits. Each bit lasts OVS*(DIV+1) clocks, where DIV is the register at address 4. The receiver samples each bit at its middle. When a character completes and status bit 0 (data-full) is 0, the byte is loaded into the data register (read at address 2) and data-full is set.
- R3: irq_rxfull is 1 exactly when data-full is 1, control bit 2 (receive interrupt enable) is 1, and neither parity error nor overrun is set.
- R4: A character with a parity error is still loaded into the data register and sets status bit 1 (parity error). irq_err is 1 when control bit 3 (error interrupt enable) is 1 and the parity error flag or the overrun flag is set. No data-full interrupt is raised while either error flag is set.
- R5: If a character completes while data-full is 1, status bit 2 (overrun) is set and the data register keeps its previous contents.
- R6: Writing 0 to a status bit at address 1 clears that flag only if the flag was read as 1 after it was last set. Writing 1 has no effect. A flag that is set and cleared in the same cycle stays set.
- R7: A write to the control register (address 0) that sets both bit 0 (receive enable) and bit 1 (transmit enable) is ignored entirely.
- R8: With transmit enable set and the transmitter idle, a write to address 2 sends that byte in the R2 format on io_out and clears status bit 3 (transmit end). Transmit end is set after the second guard bit. A data write while the transmitter is busy, or while transmit enable is 0, is ignored.
- R9: dma_req is 1 when control bit 4 (DMA enable) is 1, data-full is 1, neither error flag is set, and the count at address 3 is nonzero. dma_data shows the data register. A dma_ack while dma_req is 1 clears data-full and decrements the count.
- R10: A character with a parity error raises no DMA request and leaves the DMA count unchanged.
- R11: When a host write to the count register and a DMA acknowledge fall in the same cycle, the count takes the written value. The acknowledge still clears data-full.
- R12: While receive enable is 0, activity on io_in changes no flag and leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| io_in | input | 1 | Card I/O line, receive side |
| io_out | output | 1 | Card I/O line, transmit side (idle high) |
| irq_rxfull | output | 1 | Receive data-full interrupt request |
| irq_err | output | 1 | Receive error interrupt request |
| dma_req | output | 1 | DMA request for a good byte |
| dma_ack | input | 1 | DMA acknowledge, one cycle |
| dma_data | output | 8 | Receive data presented to DMA |

## Verification
The DMA acknowledge and a host write of the DMA count can land on the same clock edge, and both try to change the count. The bench provokes this by leaving a good byte pending with its request up, then driving dma_ack and the count write in the same cycle. It judges the outcome by reading the count back as the written value and the data-full flag as cleared. A second overlap is a new character completing while data-full is still set. This is provoked by sending two characters with no service in between, and it is judged by the overrun flag together with an unchanged data register.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int DATA_W = 8;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_DIV  = 3'd4;

  localparam int C_RXEN = 0;
  localparam int C_TXEN = 1;
  localparam int C_RIE  = 2;
  localparam int C_EIE  = 3;
  localparam int C_DMAE = 4;

  localparam int S_RDRF = 0;
  localparam int S_PER  = 1;
  localparam int S_ORER = 2;
  localparam int S_TEND = 3;
  localparam int NFLAG  = 4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_GUARD} rx_st_t;

  function automatic logic even_par(input logic [DATA_W-1:0] d);
    return ^d;
  endfunction

  function automatic logic par_bad(input logic [DATA_W-1:0] d, input logic p);
    return even_par(d) ^ p;
  endfunction

  function automatic logic [7:0] pack_status(input logic [NFLAG-1:0] f);
    return {{(8-NFLAG){1'b0}}, f};
  endfunction
endpackage

// File: rtl/sc_tick_gen.sv
module sc_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line_in,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);

  logic          s1, s2;
  rx_st_t        st;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
      done <= 1'b0;
      data <= '0;
      perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else if (tick) begin
        case (st)
          RX_IDLE: if (!s2) begin
            st   <= RX_START;
            tcnt <= '0;
          end
          RX_START: if (tcnt == CW'(OVS/2 - 1)) begin
            tcnt <= '0;
            bidx <= '0;
            st   <= s2 ? RX_IDLE : RX_BITS;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          RX_BITS: if (tcnt == CW'(OVS - 1)) begin
            tcnt <= '0;
            if (bidx == BW'(DATA_W)) begin
              done <= 1'b1;
              data <= sh;
              perr <= par_bad(sh, s2);
              st   <= RX_GUARD;
            end else begin
              sh   <= {s2, sh[DATA_W-1:1]};
              bidx <= bidx + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
          default: if (tcnt == CW'(OVS - 1)) begin
            st <= RX_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        endcase
      end
    end
  end

  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              busy,
  output logic              done,
  output logic              line_out
);
  localparam int FW = DATA_W + 4;
  localparam int CW = $clog2(OVS);
  localparam int NW = $clog2(FW);

  logic [FW-1:0] sh;
  logic [CW-1:0] tcnt;
  logic [NW-1:0] nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      tcnt <= '0;
      nb   <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh   <= {2'b11, even_par(tx_byte), tx_byte, 1'b0};
        tcnt <= '0;
        nb   <= '0;
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (tcnt == CW'(OVS - 1)) begin
          tcnt <= '0;
          sh   <= {1'b1, sh[FW-1:1]};
          if (nb == NW'(FW - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            nb <= nb + 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign line_out = sh[0];

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out); // R8
  AST_TX_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: rtl/sc_regs.sv
module sc_regs
  import sc_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              tx_busy,
  input  logic              tx_done,
  output logic              rx_en,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte,
  output logic [DIV_W-1:0]  div,
  output logic              irq_rxfull,
  output logic              irq_err,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic [DATA_W-1:0] dma_data
);
  logic [4:0]        ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rdr_q;
  logic [7:0]        cnt_q;
  logic [NFLAG-1:0]  flg, seen, set_evt, drop_evt, clr_evt;

  logic wr_ctrl, ctrl_ok, wr_stat, rd_stat, wr_data, wr_cnt, wr_div;
  logic load_evt, ovr_evt, dma_take, err_any;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign ctrl_ok  = wr_ctrl && !(bus_wdata[C_RXEN] && bus_wdata[C_TXEN]);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign rd_stat  = bus_rd && (bus_addr == A_STAT);
  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign wr_cnt   = bus_wr && (bus_addr == A_CNT);
  assign wr_div   = bus_wr && (bus_addr == A_DIV);

  assign rx_en    = ctrl_q[C_RXEN];
  assign tx_start = wr_data && ctrl_q[C_TXEN] && !tx_busy;
  assign tx_byte  = bus_wdata[DATA_W-1:0];
  assign div      = div_q;

  assign load_evt = rx_done && !flg[S_RDRF];
  assign ovr_evt  = rx_done && flg[S_RDRF];
  assign err_any  = flg[S_PER] || flg[S_ORER];
  assign dma_take = dma_ack && dma_req;

  always_comb begin
    set_evt          = '0;
    set_evt[S_RDRF]  = load_evt;
    set_evt[S_PER]   = load_evt && rx_perr;
    set_evt[S_ORER]  = ovr_evt;
    set_evt[S_TEND]  = tx_done;
    drop_evt         = '0;
    drop_evt[S_RDRF] = dma_take;
    drop_evt[S_TEND] = tx_start;
    for (int i = 0; i < NFLAG; i++) begin
      clr_evt[i] = wr_stat && !bus_wdata[i] && seen[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg  <= '0;
      seen <= '0;
    end else begin
      for (int i = 0; i < NFLAG; i++) begin
        if (set_evt[i]) begin
          flg[i]  <= 1'b1;
          seen[i] <= 1'b0;
        end else if (clr_evt[i] || drop_evt[i]) begin
          flg[i]  <= 1'b0;
          seen[i] <= 1'b0;
        end else if (!flg[i]) begin
          seen[i] <= 1'b0;
        end else if (rd_stat) begin
          seen[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      rdr_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_ok) ctrl_q <= bus_wdata[4:0];
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
      if (load_evt) rdr_q <= rx_data;
      if (wr_cnt) cnt_q <= bus_wdata;
      else if (dma_take) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign irq_rxfull = flg[S_RDRF] && ctrl_q[C_RIE] && !err_any;
  assign irq_err    = ctrl_q[C_EIE] && err_any;
  assign dma_req    = ctrl_q[C_DMAE] && flg[S_RDRF] && !err_any && (cnt_q != 8'd0);
  assign dma_data   = rdr_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {3'b000, ctrl_q};
      A_STAT:  bus_rdata = pack_status(flg);
      A_DATA:  bus_rdata = 8'(rdr_q);
      A_CNT:   bus_rdata = cnt_q;
      A_DIV:   bus_rdata = 8'(div_q);
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_en && ctrl_q[C_TXEN])); // R7
  AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> flg[S_RDRF]); // R2
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (rdr_q == $past(rdr_q)) && flg[S_ORER]); // R5
  AST_ERR_BLOCKS_RXI: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[S_PER] || flg[S_ORER]) |-> !irq_rxfull && !dma_req); // R4
  AST_DMA_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_take && !wr_cnt) |=> cnt_q == $past(cnt_q) - 8'd1); // R9
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(bus_wdata)); // R11
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[S_ORER] |=> flg[S_ORER]); // R6
endmodule

// File: rtl/sc_char_engine.sv
module sc_char_engine
  import sc_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       io_in,
  output logic       io_out,
  output logic       irq_rxfull,
  output logic       irq_err,
  output logic       dma_req,
  input  logic       dma_ack,
  output logic [7:0] dma_data
);
  logic              tick, rx_en, rx_done, rx_perr, tx_start, tx_busy, tx_done;
  logic [DATA_W-1:0] rx_data, tx_byte, dma_q;
  logic [DIV_W-1:0]  div;

  sc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick));

  sc_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .line_in(io_in),
    .done(rx_done), .data(rx_data), .perr(rx_perr));

  sc_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start), .tx_byte(tx_byte),
    .busy(tx_busy), .done(tx_done), .line_out(io_out));

  sc_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .rx_data(rx_data), .rx_perr(rx_perr),
    .tx_busy(tx_busy), .tx_done(tx_done), .rx_en(rx_en),
    .tx_start(tx_start), .tx_byte(tx_byte), .div(div),
    .irq_rxfull(irq_rxfull), .irq_err(irq_err), .dma_req(dma_req),
    .dma_ack(dma_ack), .dma_data(dma_q));

  assign dma_data = 8'(dma_q);
endmodule

// File: tb/sc_char_engine_test.sv
module sc_char_engine_test;
  localparam int CLK_PER  = 10;
  localparam int BIT_CLKS = 32;
  localparam int BIT_T    = CLK_PER * BIT_CLKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       io_in = 1'b1;
  logic       io_out, irq_rxfull, irq_err, dma_req;
  logic       dma_ack = 1'b0;
  logic [7:0] dma_data;

  int n_checks = 0, n_fail = 0;
  int mon_checks = 0, mon_fail = 0;
  logic [7:0] tx_q[$];
  logic [7:0] dma_q[$];
  logic dma_mode = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  sc_char_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .io_in(io_in), .io_out(io_out), .irq_rxfull(irq_rxfull),
    .irq_err(irq_err), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_data(dma_data));

  function automatic logic ref_par(input logic [7:0] b);
    logic p = 1'b0;
    for (int i = 0; i < 8; i++) if (b[i]) p = ~p;
    return p;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] b, input logic bad);
    logic p = ref_par(b) ^ bad;
    if (dma_mode && !bad) dma_q.push_back(b);
    io_in = 1'b0; #(BIT_T);
    for (int i = 0; i < 8; i++) begin io_in = b[i]; #(BIT_T); end
    io_in = p; #(BIT_T);
    io_in = 1'b1; #(2*BIT_T);
  endtask

  task automatic tx_send(input logic [7:0] b);
    tx_q.push_back(b);
    bus_write(3'd2, b);
  endtask

  task automatic clear_flags;
    logic [7:0] d;
    bus_read(3'd1, d);
    bus_write(3'd1, 8'h00);
  endtask

  task automatic dma_service(input string tag);
    logic [7:0] e;
    @(negedge clk);
    check({tag, " dma_req"}, dma_req, 1);
    e = (dma_q.size() > 0) ? dma_q.pop_front() : 8'hxx;
    check({tag, " dma_data"}, dma_data, e);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  // TX line monitor: decodes frames, compares against the scoreboard queue
  always begin
    logic [7:0] got, exp;
    logic ok;
    @(negedge io_out);
    #(BIT_T/2);
    ok = (io_out == 1'b0);
    for (int i = 0; i < 8; i++) begin #(BIT_T); got[i] = io_out; end
    #(BIT_T); ok = ok && (io_out == ref_par(got));
    #(BIT_T); ok = ok && io_out;
    #(BIT_T); ok = ok && io_out;
    mon_checks++;
    if (tx_q.size() == 0) begin
      mon_fail++;
      $display("FAIL R8 unexpected frame actual=%0h expected=none", got);
    end else begin
      exp = tx_q.pop_front();
      if (!ok || got !== exp) begin
        mon_fail++;
        $display("FAIL R8 tx frame actual=%0h ok=%0d expected=%0h", got, ok, exp);
      end
    end
  end

  initial begin
    #(CLK_PER * 150000);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks + mon_checks + 1,
             n_fail + mon_fail + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    #(CLK_PER*3 + 2);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(3'd1, d); check("R1 status", d, 8'h00);
    bus_read(3'd0, d); check("R1 ctrl", d, 8'h00);
    bus_read(3'd3, d); check("R1 count", d, 8'h00);
    check("R1 io_out", io_out, 1);
    check("R1 irqs", {irq_rxfull, irq_err, dma_req}, 0);

    bus_write(3'd4, 8'd1);
    bus_write(3'd0, 8'h0D); // rx enable, rie, eie

    // R2 R3 good character
    send_char(8'hA5, 1'b0);
    bus_read(3'd1, d); check("R2 status full", d, 8'h01);
    bus_read(3'd2, d); check("R2 data", d, 8'hA5);
    check("R3 irq_rxfull", irq_rxfull, 1);
    check("R3 irq_err", irq_err, 0);

    // R6 clear rules
    bus_write(3'd1, 8'hFF);
    bus_read(3'd1, d); check("R6 write one keeps", d, 8'h01);
    bus_write(3'd1, 8'h00);
    bus_read(3'd1, d); check("R6 clear after read", d, 8'h00);
    check("R3 irq dropped", irq_rxfull, 0);

    // R5 overrun
    send_char(8'h3C, 1'b0);
    bus_write(3'd1, 8'h00);
    bus_read(3'd1, d); check("R6 clear without read ignored", d, 8'h01);
    send_char(8'h77, 1'b0);
    bus_read(3'd1, d); check("R5 overrun flag", d, 8'h05);
    bus_read(3'd2, d); check("R5 data kept", d, 8'h3C);
    check("R4 overrun irq_err", irq_err, 1);
    check("R4 no rxfull on overrun", irq_rxfull, 0);
    clear_flags();

    // R4 parity error
    send_char(8'h5A, 1'b1);
    bus_read(3'd1, d); check("R4 parity status", d, 8'h03);
    bus_read(3'd2, d); check("R4 data delivered", d, 8'h5A);
    check("R4 irq_err", irq_err, 1);
    check("R4 irq_rxfull off", irq_rxfull, 0);
    clear_flags();
    bus_read(3'd1, d); check("R6 cleared all", d, 8'h00);

    // R7 both enables
    bus_write(3'd0, 8'h03);
    bus_read(3'd0, d); check("R7 ignored write", d, 8'h0D);

    // R12 receive disabled
    bus_write(3'd0, 8'h0C);
    send_char(8'hE1, 1'b0);
    bus_read(3'd1, d); check("R12 no flag", d, 8'h00);
    bus_read(3'd2, d); check("R12 data kept", d, 8'h5A);

    // R8 transmit
    bus_write(3'd0, 8'h02);
    tx_send(8'hC3);
    bus_write(3'd2, 8'h11); // busy: ignored
    bus_read(3'd1, d); check("R8 tend low while busy", d, 8'h00);
    #(13*BIT_T);
    bus_read(3'd1, d); check("R8 tend set", d, 8'h08);
    tx_send(8'h81);
    bus_read(3'd1, d); check("R8 tend cleared by write", d, 8'h00);
    #(13*BIT_T);
    bus_read(3'd1, d); check("R8 tend after second", d, 8'h08);
    bus_write(3'd0, 8'h00);
    bus_write(3'd2, 8'h42); // transmit disabled: ignored
    #(13*BIT_T);
    bus_read(3'd1, d); check("R8 disabled write keeps tend", d, 8'h08);
    check("R8 queue drained", tx_q.size(), 0);
    clear_flags();

    // R9 R10 DMA drain of good bytes
    bus_write(3'd0, 8'h19); // rx enable, eie, dma enable
    bus_write(3'd3, 8'd3);
    dma_mode = 1'b1;
    send_char(8'h12, 1'b0);
    dma_service("R9 first");
    bus_read(3'd3, d); check("R9 count dec", d, 8'd2);
    send_char(8'h99, 1'b1);
    check("R10 no req on error", dma_req, 0);
    bus_read(3'd3, d); check("R10 count unchanged", d, 8'd2);
    clear_flags();
    send_char(8'h34, 1'b0);
    dma_service("R9 second");
    send_char(8'h56, 1'b0);
    dma_service("R9 third");
    bus_read(3'd3, d); check("R9 count zero", d, 8'd0);
    dma_mode = 1'b0;
    send_char(8'h78, 1'b0);
    check("R9 no req at zero", dma_req, 0);
    bus_read(3'd1, d); check("R9 byte waits", d, 8'h01);
    bus_read(3'd2, d); check("R9 waiting data", d, 8'h78);
    bus_write(3'd1, 8'h00);

    // R11 count write and acknowledge together
    bus_write(3'd3, 8'd5);
    send_char(8'h6B, 1'b0);
    @(negedge clk);
    check("R11 req up", dma_req, 1);
    check("R11 data", dma_data, 8'h6B);
    bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 8'd9; dma_ack = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; dma_ack = 1'b0;
    bus_read(3'd3, d); check("R11 write wins", d, 8'd9);
    bus_read(3'd1, d); check("R11 ack cleared full", d, 8'h00);
    check("R9 dma queue empty", dma_q.size(), 0);

    #(BIT_T);
    $display("  [TB] %0d tests run, %0d failed", n_checks + mon_checks,
             n_fail + mon_fail);
    $finish;
  end
endmodule